// File: doc/BRIEF.md
# OSD Plane Alpha Blending Mixer

This block blends one on-screen-display pixel over the matching pixel of the lower video/background layer, one pixel per clock. Each incoming OSD pixel carries a region descriptor made of a pixel format, an antialiasing enable and a 4-bit region alpha. The mixer derives the OSD colour and an 8-bit alpha from that descriptor. Palette pixels are looked up in a 256-entry colour table that is loaded through a separate write port. True-colour pixels are unpacked; their components are assumed to be already in Y, Cb, Cr order.

Both the OSD colour and the lower pixel are in YCbCr form. The result is a rounded weighted blend for each component. It appears with `out_valid` a fixed two cycles after the pixel is accepted, and the pipeline takes a new pixel every cycle.

Top module: `osd_alpha_mixer`

## Requirements
- R1: After reset, `out_valid` is low until a pixel has been accepted.
- R2: A pixel accepted with `in_valid` high at a clock edge appears with `out_valid` high two clock edges later. Consecutive pixels keep their order with no gaps.
- R3: Format code 0 is palette mode. `in_pix[7:0]` indexes a 256-entry table whose 30-bit entry holds alpha in [29:24], Y in [23:16], Cb in [15:8] and Cr in [7:0]. The entry's Y/Cb/Cr is the OSD colour.
- R4: A table write with `clut_we` high at a clock edge is seen by every pixel accepted at a later edge, including a rewrite of an entry that is already in use.
- R5: In palette mode with `in_aa_en` low, the alpha is the 4-bit region alpha repeated in both nibbles (r → {r,r}).
- R6: In palette mode with `in_aa_en` high, the alpha is the entry's 6-bit alpha `e` widened to {e, e[5:4]}.
- R7: Format code 1 (RGB565, [15:11],[10:5],[4:0] giving Y,Cb,Cr) widens each field by repeating its top bits to 8 bits. It uses the region alpha {r,r}.
- R8: Format code 2 (ARGB1555: alpha bit 15, then 5-bit fields [14:10],[9:5],[4:0]) uses alpha 255 when bit 15 is set and 0 otherwise.
- R9: Format code 3 (ARGB4444: alpha [15:12], fields [11:8],[7:4],[3:0]) uses alpha {a,a} and components {c,c}.
- R10: Each output component equals (a*osd + (255-a)*lower + 127) / 255, with integer division.
- R11: An alpha of 0 gives the lower pixel unchanged. An alpha of 255 gives the OSD colour unchanged.
- R12: `in_aa_en` has no effect on the three true-colour formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | OSD pixel present |
| in_pix | input | 16 | OSD pixel word |
| in_fmt | input | 2 | Region format: 0 palette, 1 RGB565, 2 ARGB1555, 3 ARGB4444 |
| in_aa_en | input | 1 | Region antialiasing enable (palette only) |
| in_region_alpha | input | 4 | Region alpha |
| in_lower_y | input | 8 | Lower layer Y |
| in_lower_cb | input | 8 | Lower layer Cb |
| in_lower_cr | input | 8 | Lower layer Cr |
| clut_we | input | 1 | Colour table write enable |
| clut_waddr | input | 8 | Colour table write index |
| clut_wdata | input | 30 | Colour table entry |
| out_valid | output | 1 | Blended pixel present |
| out_y | output | 8 | Blended Y |
| out_cb | output | 8 | Blended Cb |
| out_cr | output | 8 | Blended Cr |

## Verification
Every pixel result is due exactly two clock edges after the edge that accepts it. Table writes take effect for a pixel accepted one edge after the write. The driver records the cycle number at which each expected pixel should appear. The monitor samples on the falling edge and checks both the value and that the arrival cycle matches the recorded one, so a pixel that arrives early or late fails even when its colour is right. Expected colours come from a bench-side model of the format, alpha and rounding rules, plus literal values for the zero and full alpha cases.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;
    localparam int COMP_W   = 8;
    localparam int ALPHA_W  = 8;
    localparam int PIX_W    = 16;
    localparam int RALPHA_W = 4;
    localparam int EALPHA_W = 6;
    localparam int ENTRY_W  = EALPHA_W + 3 * COMP_W;
    localparam int NUM_COMP = 3;

    typedef enum logic [1:0] {
        FMT_CLUT8    = 2'd0,
        FMT_RGB565   = 2'd1,
        FMT_ARGB1555 = 2'd2,
        FMT_ARGB4444 = 2'd3
    } osd_fmt_e;

    typedef struct packed {
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] cb;
        logic [COMP_W-1:0] cr;
    } ycc_t;

    typedef struct packed {
        logic                valid;
        logic [PIX_W-1:0]    pix;
        osd_fmt_e            fmt;
        logic                aa_en;
        logic [RALPHA_W-1:0] ralpha;
        ycc_t                lower;
    } stage1_t;

    typedef struct packed {
        logic valid;
        ycc_t pix;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } mix_state_t;
endpackage

// File: rtl/osd_clut_ram.sv
module osd_clut_ram #(
    parameter int AW = 8,
    parameter int DW = 30
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/osd_src_decode.sv
module osd_src_decode
    import osd_mix_pkg::*;
(
    input  osd_fmt_e              fmt,
    input  logic                  aa_en,
    input  logic [RALPHA_W-1:0]   ralpha,
    input  logic [PIX_W-1:0]      pix,
    input  logic [ENTRY_W-1:0]    entry,
    output ycc_t                  osd_col,
    output logic [ALPHA_W-1:0]    alpha
);
    logic [EALPHA_W-1:0] ent_a;
    logic [ALPHA_W-1:0]  reg_a;

    always_comb begin
        ent_a = entry[ENTRY_W-1 -: EALPHA_W];
        reg_a = {ralpha, ralpha};
        osd_col = '0;
        alpha   = '0;
        unique case (fmt)
            FMT_CLUT8: begin
                osd_col = entry[3*COMP_W-1:0];
                alpha   = aa_en ? {ent_a, ent_a[EALPHA_W-1 -: 2]} : reg_a;
            end
            FMT_RGB565: begin
                osd_col.y  = {pix[15:11], pix[15:13]};
                osd_col.cb = {pix[10:5],  pix[10:9]};
                osd_col.cr = {pix[4:0],   pix[4:2]};
                alpha      = reg_a;
            end
            FMT_ARGB1555: begin
                osd_col.y  = {pix[14:10], pix[14:12]};
                osd_col.cb = {pix[9:5],   pix[9:7]};
                osd_col.cr = {pix[4:0],   pix[4:2]};
                alpha      = {ALPHA_W{pix[15]}};
            end
            default: begin
                osd_col.y  = {pix[11:8], pix[11:8]};
                osd_col.cb = {pix[7:4],  pix[7:4]};
                osd_col.cr = {pix[3:0],  pix[3:0]};
                alpha      = {pix[15:12], pix[15:12]};
            end
        endcase
    end

    always_comb begin
        // R8
        if (fmt == FMT_ARGB1555)
            a1555_binary_chk: assert (alpha == '0 || alpha == '1);
        // R12
        if (fmt != FMT_CLUT8 && fmt != FMT_ARGB1555)
            tc_alpha_nibble_chk: assert (alpha[7:4] == alpha[3:0]);
    end
endmodule

// File: rtl/osd_blend_lane.sv
module osd_blend_lane
    import osd_mix_pkg::*;
(
    input  logic [ALPHA_W-1:0] alpha,
    input  logic [COMP_W-1:0]  osd_c,
    input  logic [COMP_W-1:0]  low_c,
    output logic [COMP_W-1:0]  mix_c
);
    localparam int ACC_W = 2 * COMP_W + 1;
    localparam logic [ACC_W-1:0] FULL = ACC_W'((1 << ALPHA_W) - 1);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(((1 << ALPHA_W) - 1) / 2);

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc   = ACC_W'(alpha) * ACC_W'(osd_c)
              + (FULL - ACC_W'(alpha)) * ACC_W'(low_c)
              + HALF;
        mix_c = COMP_W'(acc / FULL);
    end

    always_comb begin
        // R10
        blend_range_chk: assert ((mix_c >= osd_c || mix_c >= low_c) &&
                                 (mix_c <= osd_c || mix_c <= low_c));
    end
endmodule

// File: rtl/osd_alpha_mixer.sv
module osd_alpha_mixer
    import osd_mix_pkg::*;
#(
    parameter int CLUT_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [15:0]         in_pix,
    input  logic [1:0]          in_fmt,
    input  logic                in_aa_en,
    input  logic [3:0]          in_region_alpha,
    input  logic [7:0]          in_lower_y,
    input  logic [7:0]          in_lower_cb,
    input  logic [7:0]          in_lower_cr,
    input  logic                clut_we,
    input  logic [CLUT_AW-1:0]  clut_waddr,
    input  logic [29:0]         clut_wdata,
    output logic                out_valid,
    output logic [7:0]          out_y,
    output logic [7:0]          out_cb,
    output logic [7:0]          out_cr
);
    mix_state_t st_d, st_q;

    logic [ENTRY_W-1:0]                entry_rd;
    ycc_t                              osd_col;
    logic [ALPHA_W-1:0]                mix_alpha;
    logic [NUM_COMP-1:0][COMP_W-1:0]   osd_arr, low_arr, mix_arr;

    osd_clut_ram #(.AW(CLUT_AW), .DW(ENTRY_W)) u_clut (
        .clk   (clk),
        .we    (clut_we),
        .waddr (clut_waddr),
        .wdata (clut_wdata),
        .raddr (in_pix[CLUT_AW-1:0]),
        .rdata (entry_rd)
    );

    osd_src_decode u_decode (
        .fmt     (st_q.s1.fmt),
        .aa_en   (st_q.s1.aa_en),
        .ralpha  (st_q.s1.ralpha),
        .pix     (st_q.s1.pix),
        .entry   (entry_rd),
        .osd_col (osd_col),
        .alpha   (mix_alpha)
    );

    assign osd_arr = osd_col;
    assign low_arr = st_q.s1.lower;

    for (genvar g = 0; g < NUM_COMP; g++) begin : g_lane
        osd_blend_lane u_lane (
            .alpha (mix_alpha),
            .osd_c (osd_arr[g]),
            .low_c (low_arr[g]),
            .mix_c (mix_arr[g])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.s1.valid    = in_valid;
        st_d.s1.pix      = in_pix;
        st_d.s1.fmt      = osd_fmt_e'(in_fmt);
        st_d.s1.aa_en    = in_aa_en;
        st_d.s1.ralpha   = in_region_alpha;
        st_d.s1.lower.y  = in_lower_y;
        st_d.s1.lower.cb = in_lower_cb;
        st_d.s1.lower.cr = in_lower_cr;
        st_d.s2.valid    = st_q.s1.valid;
        st_d.s2.pix      = mix_arr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.s2.valid;
    assign out_y     = st_q.s2.pix.y;
    assign out_cb    = st_q.s2.pix.cb;
    assign out_cr    = st_q.s2.pix.cr;

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
    // R11
    zero_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.valid && mix_alpha == '0) |=> ({out_y, out_cb, out_cr} == $past(st_q.s1.lower)));
    // R11
    full_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.valid && mix_alpha == '1) |=> ({out_y, out_cb, out_cr} == $past(osd_col)));
endmodule

// File: tb/test_osd_alpha_mixer.sv
`timescale 1ns/1ps
module test_osd_alpha_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_pix = '0;
    logic [1:0]  in_fmt = '0;
    logic        in_aa_en = 1'b0;
    logic [3:0]  in_region_alpha = '0;
    logic [7:0]  in_lower_y = '0, in_lower_cb = '0, in_lower_cr = '0;
    logic        clut_we = 1'b0;
    logic [7:0]  clut_waddr = '0;
    logic [29:0] clut_wdata = '0;
    logic        out_valid;
    logic [7:0]  out_y, out_cb, out_cr;

    osd_alpha_mixer i_osd_alpha_mixer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_fmt(in_fmt), .in_aa_en(in_aa_en), .in_region_alpha(in_region_alpha),
        .in_lower_y(in_lower_y), .in_lower_cb(in_lower_cb), .in_lower_cr(in_lower_cr),
        .clut_we(clut_we), .clut_waddr(clut_waddr), .clut_wdata(clut_wdata),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [23:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [29:0] clut_m [256];
    int          cyc = 0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mixc(int a, int o, int l);
        return (a * o + (255 - a) * l + 127) / 255;
    endfunction

    function automatic logic [23:0] model(logic [15:0] p, logic [1:0] f, logic aa,
                                          logic [3:0] ra, logic [23:0] low);
        logic [23:0] col;
        int a;
        logic [29:0] e;
        case (f)
            2'd0: begin
                e = clut_m[p[7:0]];
                col = e[23:0];
                a = aa ? int'({e[29:24], e[29:28]}) : int'({ra, ra});
            end
            2'd1: begin
                col = {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
                a = int'({ra, ra});
            end
            2'd2: begin
                col = {p[14:10], p[14:12], p[9:5], p[9:7], p[4:0], p[4:2]};
                a = p[15] ? 255 : 0;
            end
            default: begin
                col = {p[11:8], p[11:8], p[7:4], p[7:4], p[3:0], p[3:0]};
                a = int'({p[15:12], p[15:12]});
            end
        endcase
        return {8'(mixc(a, col[23:16], low[23:16])),
                8'(mixc(a, col[15:8],  low[15:8])),
                8'(mixc(a, col[7:0],   low[7:0]))};
    endfunction

    task automatic clut_write(logic [7:0] idx, logic [29:0] val);
        @(negedge clk);
        in_valid = 1'b0;
        clut_we = 1'b1; clut_waddr = idx; clut_wdata = val;
        clut_m[idx] = val;
    endtask

    task automatic drive(logic [15:0] p, logic [1:0] f, logic aa, logic [3:0] ra,
                         logic [23:0] low, bit use_lit, logic [23:0] lit, string tag);
        item_t it;
        @(negedge clk);
        clut_we = 1'b0;
        in_valid = 1'b1; in_pix = p; in_fmt = f; in_aa_en = aa; in_region_alpha = ra;
        {in_lower_y, in_lower_cb, in_lower_cr} = low;
        it.exp = use_lit ? lit : model(p, f, aa, ra, low);
        it.due = cyc + 2;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; clut_we = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R2 unexpected output actual=%h expected=none",
                         {out_y, out_cb, out_cr});
            end else begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({out_y, out_cb, out_cr} !== it.exp) begin
                    errors++;
                    $display("FAIL %s data actual=%h expected=%h", it.tag,
                             {out_y, out_cb, out_cr}, it.exp);
                end
                checks++;
                if (cyc != it.due) begin
                    errors++;
                    $display("FAIL R2 latency (%s) actual=%0d expected=%0d", it.tag, cyc, it.due);
                end
            end
        end
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid after reset actual=%b expected=0", out_valid);
        end

        // R3 fill every table entry with a computed pattern
        for (int i = 0; i < 256; i++)
            clut_write(8'(i), {6'(i * 7), 8'(i), 8'(255 - i), 8'(i * 3)});
        clut_write(8'd3, {6'd63, 8'd200, 8'd100, 8'd50});

        // R11 region alpha 0 passes the lower pixel
        drive(16'h0003, 2'd0, 1'b0, 4'h0, 24'h102030, 1'b1, 24'h102030, "R11 zero alpha");
        // R11/R5 region alpha F gives table colour
        drive(16'h0003, 2'd0, 1'b0, 4'hF, 24'h102030, 1'b1, 24'hC86432, "R11 R5 full alpha");
        // R5 R10 half alpha
        drive(16'h0003, 2'd0, 1'b0, 4'h8, 24'h102030, 1'b0, '0, "R5 R10 region alpha");
        // R6 entry alpha 63 -> 255
        drive(16'h0003, 2'd0, 1'b1, 4'h0, 24'h405060, 1'b1, 24'hC86432, "R6 entry alpha");
        // R6 R3 boundary indices
        drive(16'h00FF, 2'd0, 1'b1, 4'h2, 24'h7F7F7F, 1'b0, '0, "R3 R6 index 255");
        drive(16'hAB00, 2'd0, 1'b1, 4'h2, 24'hFF0080, 1'b0, '0, "R3 R6 index 0");
        drive(16'h0025, 2'd0, 1'b1, 4'h9, 24'h00FF10, 1'b0, '0, "R6 R10 mid entry");
        idle(3);

        // R7 RGB565
        drive(16'hF81F, 2'd1, 1'b0, 4'hF, 24'h112233, 1'b1, 24'hFF00FF, "R7 rgb565 full");
        drive(16'h7BEF, 2'd1, 1'b0, 4'h5, 24'hA0B0C0, 1'b0, '0, "R7 rgb565 blend");
        // R12 aa enable ignored for true colour
        drive(16'h7BEF, 2'd1, 1'b1, 4'h5, 24'hA0B0C0, 1'b0, '0, "R12 rgb565 aa");
        // R8 ARGB1555
        drive(16'h7FFF, 2'd2, 1'b0, 4'hF, 24'h0A0B0C, 1'b1, 24'h0A0B0C, "R8 1555 alpha0");
        drive(16'h8421, 2'd2, 1'b1, 4'h0, 24'h0A0B0C, 1'b1, 24'h080808, "R8 R12 1555 alpha1");
        // R9 ARGB4444
        drive(16'h9A5F, 2'd3, 1'b0, 4'h0, 24'h204060, 1'b0, '0, "R9 4444 blend");
        drive(16'h0ABC, 2'd3, 1'b1, 4'hF, 24'h204060, 1'b1, 24'h204060, "R9 R12 4444 zero");
        idle(4);

        // R4 rewrite entry then read it on the next cycle
        clut_write(8'd3, {6'd63, 8'd17, 8'd34, 8'd51});
        drive(16'h0003, 2'd0, 1'b1, 4'h0, 24'h000000, 1'b1, 24'h112233, "R4 rewrite");
        idle(3);

        // R2 back-to-back mixed stream
        for (int k = 0; k < 24; k++)
            drive(16'((k * 16'h1F3B) ^ 16'h5A5A), 2'(k), 1'(k >> 2), 4'(k * 5),
                  24'(k * 24'h0B1D29), 1'b0, '0, "R2 R10 stream");
        idle(5);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending results actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule